// File: doc/BRIEF.md
# Dual-Mode Serial Frame Receiver

This block accepts 10-bit command words from a slow serial link made of a data line and a clock line. A faster system clock samples both lines. Each word carries a 2-bit channel address followed by an 8-bit value, most significant bit first. A static mode input selects how the frame boundaries are found:

- In load-strobe mode, an extra active-low load line commits the word.
- In two-line mode, the frame boundaries come from the order in which the data and clock lines change. A start condition opens the frame and a stop condition closes it.

When a word is committed, the block raises a one-cycle valid pulse and holds the word steady on its output until the next commit. A chain output carries the bit that falls off the far end of the shift register. That output can feed the data input of a second receiver, so several receivers can share one data wire.

Top module: `sframe_rx`

## Requirements
- R1: While reset is held, and after it is released, `word_valid` is 0, `word_out` is 0 and `chain_out` is 0.
- R2: In load-strobe mode (`two_wire_mode`=0), the data line is shifted in on each falling edge of `ser_clk`. A falling edge of `load_n` commits the word and gives a `word_valid` pulse that lasts exactly one cycle. The first bit shifted lands in `word_out[9]` and the last bit lands in `word_out[0]`.
- R3: In load-strobe mode, if more than 10 bits arrive before the load, only the 10 most recent bits are committed.
- R4: In load-strobe mode the shift register is 10 stages long. `chain_out` shows the bit that was shifted in 10 clock falls earlier.
- R5: In two-line mode (`two_wire_mode`=1), a start condition is `ser_dat` falling while `ser_clk` is high. The next `ser_clk` fall shifts in a forced 0, and each later `ser_clk` fall shifts in one data bit.
- R6: In two-line mode, a stop condition is `ser_dat` rising while `ser_clk` is high inside a frame. It commits the last 10 data bits with a single-cycle `word_valid` pulse, using the same bit order as R2.
- R7: In two-line mode the shift register is 11 stages long. After a start condition and 10 data bits, `chain_out` shows the forced 0.
- R8: Events that are not framing events in the current mode commit nothing. In two-line mode a `load_n` fall has no effect. In load-strobe mode a `ser_dat` rise while `ser_clk` is high has no effect.
- R9: In two-line mode, a `ser_dat` rise after a start condition but before the first clock fall cancels the frame without a commit. A new start condition inside a frame restarts it, so only the bits after the restart are committed.
- R10: `word_out` changes only in the cycle where `word_valid` is 1. At all other times it holds its value.

Each receiver stores the last 10 bits it saw. That is why committing in the wrong mode, or counting a stale bit, shows up at once in `word_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_wire_mode | input | 1 | 1 selects two-line framing, 0 selects load-strobe framing |
| ser_clk | input | 1 | Serial clock line, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| load_n | input | 1 | Active-low load strobe, used in load-strobe mode only |
| word_valid | output | 1 | One-cycle pulse when a word is committed |
| word_out | output | 10 | Last committed word: {address[1:0], value[7:0]} |
| chain_out | output | 1 | Bit leaving the end of the shift register |

## Verification
The bench targets the two stage counts of the shift register. It tells them apart through `chain_out` after a frame whose first data bit is 1. A receiver that kept 10 stages in two-line mode would drive 1 there instead of the forced 0. It also sends overlong frames in load-strobe mode, which catch a design that commits the oldest bits instead of the newest. It drives a stray load strobe in two-line mode and a data rise under a high clock in load-strobe mode; a receiver that ignored the mode would produce a spurious pulse. Cancelled and restarted starts check that a half-formed start never commits, and that a restart discards the bits already taken.

// File: rtl/sframe_pkg.sv
package sframe_pkg;

  // Two-line framing progress
  typedef enum logic [1:0] {
    TW_IDLE  = 2'd0,  // waiting for a start condition
    TW_ARMED = 2'd1,  // data fell under a high clock, first clock fall pending
    TW_BODY  = 2'd2   // inside a frame, shifting bits
  } tw_state_e;

endpackage

// File: rtl/sframe_sync.sv
module sframe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sframe_tw_ctrl.sv
module sframe_tw_ctrl
  import sframe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sck_lvl,
  input  logic sck_fall,
  input  logic sda_fall,
  input  logic sda_rise,
  output logic shift_en,
  output logic force_zero,
  output logic stop_det
);

  tw_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    shift_en   = 1'b0;
    force_zero = 1'b0;
    stop_det   = 1'b0;
    if (!enable) begin
      state_d = TW_IDLE;
    end else begin
      unique case (state_q)
        TW_IDLE: begin
          if (sda_fall && sck_lvl) state_d = TW_ARMED;
        end
        TW_ARMED: begin
          if (sda_rise && sck_lvl) begin
            state_d = TW_IDLE;
          end else if (sck_fall) begin
            shift_en   = 1'b1;
            force_zero = 1'b1;
            state_d    = TW_BODY;
          end
        end
        TW_BODY: begin
          if (sck_fall) begin
            shift_en = 1'b1;
          end else if (sda_fall && sck_lvl) begin
            state_d = TW_ARMED;
          end else if (sda_rise && sck_lvl) begin
            stop_det = 1'b1;
            state_d  = TW_IDLE;
          end
        end
        default: state_d = TW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TW_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sframe_shreg.sv
module sframe_shreg #(
  parameter int LEN = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] q
);

  logic [LEN-1:0] q_d;

  always_comb begin
    q_d = q;
    if (shift_en) q_d = {q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/sframe_rx.sv
module sframe_rx #(
  parameter int WORD_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_wire_mode,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              load_n,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              chain_out
);

  localparam int SHIFT_LEN = WORD_W + 1;

  // synchronised lines: {load, data, clock}
  logic [2:0] lines_s;
  logic       sck_s, sda_s, ld_s;
  logic       sck_q, sda_q, ld_q;

  sframe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({load_n, ser_dat, ser_clk}),
    .sync_out (lines_s)
  );

  assign {ld_s, sda_s, sck_s} = lines_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      sda_q <= 1'b1;
      ld_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      sda_q <= sda_s;
      ld_q  <= ld_s;
    end
  end

  logic sck_fall, sda_fall, sda_rise, ld_fall;
  assign sck_fall = sck_q & ~sck_s;
  assign sda_fall = sda_q & ~sda_s;
  assign sda_rise = ~sda_q & sda_s;
  assign ld_fall  = ld_q & ~ld_s;

  // two-line framing
  logic tw_shift, tw_zero, stop_det;

  sframe_tw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (two_wire_mode),
    .sck_lvl    (sck_s),
    .sck_fall   (sck_fall),
    .sda_fall   (sda_fall),
    .sda_rise   (sda_rise),
    .shift_en   (tw_shift),
    .force_zero (tw_zero),
    .stop_det   (stop_det)
  );

  logic zero_shift;
  assign zero_shift = tw_shift & tw_zero;

  // shift register shared by both modes
  logic                 sh_en, sh_din;
  logic [SHIFT_LEN-1:0] shreg;

  assign sh_en  = two_wire_mode ? tw_shift : sck_fall;
  assign sh_din = two_wire_mode ? (sda_s & ~tw_zero) : sda_s;

  sframe_shreg #(.LEN(SHIFT_LEN)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sh_en),
    .din      (sh_din),
    .q        (shreg)
  );

  // commit
  logic commit;
  assign commit = two_wire_mode ? stop_det : ld_fall;

  logic              valid_d;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    valid_d = commit;
    word_d  = word_out;
    if (commit) word_d = shreg[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_out   <= '0;
    end else begin
      word_valid <= valid_d;
      word_out   <= word_d;
    end
  end

  assign chain_out = two_wire_mode ? shreg[SHIFT_LEN-1] : shreg[WORD_W-1];

endmodule

// File: rtl/sframe_rx_chk.sv
module sframe_rx_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              two_wire,
  input logic              frame_valid,
  input logic [WORD_W-1:0] frame_word,
  input logic              stop_det,
  input logic              ld_fall,
  input logic              zero_shift,
  input logic              shreg_lsb
);

  // R2, R6: commit pulse lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R10: word only moves together with the valid pulse
  a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_word));

  // R6: in two-line mode a commit follows a detected stop
  a_r6_stop_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (two_wire && $past(two_wire) && frame_valid) |-> $past(stop_det));

  // R8: load strobe ignored in two-line mode
  a_r8_no_load_2w: assert property (@(posedge clk) disable iff (!rst_n)
    (two_wire && ld_fall && !stop_det) |=> !frame_valid);

  // R5: the shift after a start condition enters a zero
  a_r5_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_shift) |-> !shreg_lsb);

endmodule

bind sframe_rx sframe_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .two_wire    (two_wire_mode),
  .frame_valid (word_valid),
  .frame_word  (word_out),
  .stop_det    (stop_det),
  .ld_fall     (ld_fall),
  .zero_shift  (zero_shift),
  .shreg_lsb   (shreg[0])
);

// File: tb/sframe_rx_test.sv
module sframe_rx_test;

  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       two_wire_mode;
  logic       ser_clk, ser_dat, load_n;
  logic       word_valid;
  logic [9:0] word_out;
  logic       chain_out;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sframe_rx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .two_wire_mode (two_wire_mode),
    .ser_clk       (ser_clk),
    .ser_dat       (ser_dat),
    .load_n        (load_n),
    .word_valid    (word_valid),
    .word_out      (word_out),
    .chain_out     (chain_out)
  );

  always @(negedge clk) if (word_valid) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  // load-strobe helpers
  task automatic lw_bit(input bit b);
    ser_dat = b; hold();
    ser_clk = 1'b0; hold();
    ser_clk = 1'b1; hold();
  endtask

  task automatic lw_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) lw_bit(v[i]);
  endtask

  task automatic lw_load();
    load_n = 1'b0; hold();
    load_n = 1'b1; hold();
  endtask

  // two-line helpers
  task automatic tw_start();
    ser_dat = 1'b0; hold();
    ser_clk = 1'b0; hold();
  endtask

  task automatic tw_bits(input logic [9:0] v);
    for (int i = 9; i >= 0; i--) begin
      ser_dat = v[i]; hold();
      ser_clk = 1'b1; hold();
      ser_clk = 1'b0; hold();
    end
  endtask

  task automatic tw_stop();
    ser_dat = 1'b0; hold();
    ser_clk = 1'b1; hold();
    ser_dat = 1'b1; hold();
  endtask

  task automatic t_reset();
    chk(word_valid == 1'b0, "R1 valid", word_valid, 0);
    chk(word_out == 10'h0, "R1 word", word_out, 0);
    chk(chain_out == 1'b0, "R1 chain", chain_out, 0);
  endtask

  task automatic t_lw_frame(input logic [9:0] w);
    int p0 = pulses;
    lw_bits({6'd0, w}, 10);
    lw_load();
    chk(pulses == p0 + 1, "R2 pulse count", pulses - p0, 1);
    chk(word_out == w, "R2 word", word_out, w);
  endtask

  task automatic t_lw_long();
    int p0 = pulses;
    lw_bits(16'h1D5A, 13); // last 10 bits = 0x15A
    lw_load();
    chk(pulses == p0 + 1, "R3 pulse count", pulses - p0, 1);
    chk(word_out == 10'h15A, "R3 newest bits", word_out, 10'h15A);
  endtask

  task automatic t_lw_chain();
    lw_bits(16'h0281, 10);
    chk(chain_out == 1'b1, "R4 chain bit9", chain_out, 1);
    lw_bit(1'b0);
    chk(chain_out == 1'b0, "R4 chain bit8", chain_out, 0);
    lw_bit(1'b0);
    chk(chain_out == 1'b1, "R4 chain bit7", chain_out, 1);
  endtask

  task automatic t_lw_stray_stop();
    int p0 = pulses;
    logic [9:0] w0 = word_out;
    ser_dat = 1'b0; hold();
    ser_dat = 1'b1; hold();   // rise with clock high
    hold();
    chk(pulses == p0, "R8 load-strobe ignores data rise", pulses - p0, 0);
    chk(word_out == w0, "R10 word held", word_out, w0);
  endtask

  task automatic t_tw_frame(input logic [9:0] w);
    int p0 = pulses;
    tw_start();
    tw_bits(w);
    tw_stop();
    chk(pulses == p0 + 1, "R6 pulse count", pulses - p0, 1);
    chk(word_out == w, "R5 R6 word", word_out, w);
  endtask

  task automatic t_tw_chain();
    tw_start();
    tw_bits(10'h3C3);
    chk(chain_out == 1'b0, "R7 chain shows forced zero", chain_out, 0);
    tw_stop();
    chk(word_out == 10'h3C3, "R7 word", word_out, 10'h3C3);
  endtask

  task automatic t_tw_load_ignored();
    int p0 = pulses;
    logic [9:0] w0 = word_out;
    lw_load();
    hold();
    chk(pulses == p0, "R8 two-line ignores load", pulses - p0, 0);
    chk(word_out == w0, "R8 word unchanged", word_out, w0);
  endtask

  task automatic t_tw_abort();
    int p0 = pulses;
    logic [9:0] w0 = word_out;
    ser_dat = 1'b0; hold();
    ser_dat = 1'b1; hold();  // cancel before first clock fall
    hold();
    chk(pulses == p0, "R9 cancel no commit", pulses - p0, 0);
    chk(word_out == w0, "R9 word unchanged", word_out, w0);
  endtask

  task automatic t_tw_restart();
    int p0 = pulses;
    tw_start();
    ser_dat = 1'b1; hold(); ser_clk = 1'b1; hold(); ser_clk = 1'b0; hold();
    ser_dat = 1'b1; hold(); ser_clk = 1'b1; hold(); ser_clk = 1'b0; hold();
    ser_dat = 1'b1; hold(); ser_clk = 1'b1; hold();
    ser_dat = 1'b0; hold();  // restart under high clock
    ser_clk = 1'b0; hold();
    tw_bits(10'h0A5);
    tw_stop();
    chk(pulses == p0 + 1, "R9 restart single commit", pulses - p0, 1);
    chk(word_out == 10'h0A5, "R9 restart word", word_out, 10'h0A5);
  endtask

  initial begin
    rst_n = 1'b0;
    two_wire_mode = 1'b0;
    ser_clk = 1'b1; ser_dat = 1'b1; load_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    hold();
    t_reset();

    t_lw_frame(10'h2A5);
    t_lw_frame(10'h3FF);
    t_lw_long();
    t_lw_chain();
    t_lw_stray_stop();

    two_wire_mode = 1'b1;
    ser_clk = 1'b1; ser_dat = 1'b1;
    hold();
    t_tw_frame(10'h2E1);
    t_tw_frame(10'h000);
    t_tw_chain();
    t_tw_load_ignored();
    t_tw_abort();
    t_tw_restart();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule